// File: doc/BRIEF.md
# VCO Band Calibration Controller

This controller chooses the switched-capacitor band code of a PLL's voltage-controlled oscillator each time a new channel is requested. A request sets the code to its middle value and turns on the loop-filter precharge. It then holds both dividers and the phase-frequency detector in reset for a programmable number of cycles and releases them together. After that it runs a binary search on the code. The analog precharge, the oscillator and the charge pump lie outside the block.

The block runs on the reference clock. The reference-divider and main-divider outputs enter through two-flop synchronizers. The first reference-divider period after release only aligns the dividers and decides nothing. Each later period settles one code bit, most significant first. A period gives a "fast" decision when the main-divider edge arrives no later than the reference-divider edge. After every decision except the last, the dividers are restarted for one cycle so that each comparison starts in phase. Once the last bit is settled, precharge is released and the loop is closed.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, band_code is the mid code 3'b100, and precharge_en, div_reset, loop_close, cal_busy and cal_done are all 0.
- R2: A chan_req sampled at a clock edge makes band_code 3'b100 and sets cal_busy and precharge_en to 1 after that edge. loop_close is 0 after that edge. Both cal_busy and precharge_en stay 1 until calibration completes.
- R3: div_reset is 1 for exactly HOLD_CYC cycles after a request. It is then 0 while the dividers run. It returns to 1 for exactly one cycle after each comparison except the last.
- R4: A comparison ends on the synchronized rising edge of the reference-divider output. It is "fast" when a synchronized main-divider rising edge came earlier in the same window or in the same cycle, and "slow" otherwise.
- R5: The search settles bit 2, then bit 1, then bit 0. Each bit is tried as 1. A fast decision keeps it at 1 and a slow decision clears it. The next lower bit is then set to 1 as its trial value. The final code is the largest code judged fast, or 0 when none is.
- R6: The first comparison window after the first release only aligns the dividers: band_code stays 3'b100 through it.
- R7: With a reference-divider ratio of N cycles, cal_done is 1 exactly HOLD_CYC + 4*N + 11 clock edges after the request edge. This spans four reference periods plus the fixed synchronizer and restart latency.
- R8: At completion, cal_busy and precharge_en fall and loop_close rises on the same edge. cal_done is 1 for exactly one cycle. loop_close stays 1 until the next request.
- R9: A chan_req while calibration is running restarts the whole sequence from the mid code. Completion timing is then counted from the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 1 | One-cycle new-channel request |
| ref_div_in | input | 1 | Reference-divider output (asynchronous) |
| main_div_in | input | 1 | Main-divider output (asynchronous) |
| band_code | output | CODE_W | VCO capacitor band code |
| precharge_en | output | 1 | Loop-filter precharge enable |
| div_reset | output | 1 | Reset for both dividers and the phase detector |
| loop_close | output | 1 | Close the PLL loop |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase count or a lost window edge moves the cal_done pulse away from its fixed cycle count after the request. That shows within one reference period of the fault. A wrong search step or a wrong fast/slow polarity leaves band_code wrong right after the decision edge, long before lock. A restart pulse that is missing or too long appears at div_reset in the cycle after a comparison. A failure to restart on a request shows as band_code not returning to mid one edge later.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    localparam int unsigned CAL_CODE_W = 3;
    localparam int unsigned CAL_HOLD   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_MEAS
    } cal_state_e;

    // One successive-approximation step on a code of up to 16 bits.
    function automatic logic [15:0] sar_step(input logic [15:0] code,
                                             input int          idx,
                                             input logic        fast);
        logic [15:0] nxt;
        nxt      = code;
        nxt[idx] = fast;
        if (idx > 0) nxt[idx-1] = 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/vbc_edge_sync.sv
module vbc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst || clr) chain <= '0;
        else            chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/vbc_sar.sv
module vbc_sar
    import vbc_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_mid,
    input  logic              decide,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              fast,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic [15:0] stepped;
    assign stepped = sar_step(16'(code), int'(bit_idx), fast);

    always_ff @(posedge clk) begin
        if (rst || load_mid) code <= MID;
        else if (decide)     code <= stepped[CODE_W-1:0];
    end
endmodule

// File: rtl/vbc_seq.sv
module vbc_seq
    import vbc_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int HOLD_CYC = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_req,
    input  logic             ref_rise,
    input  logic             main_rise,
    output logic             hold,
    output logic             active,
    output logic             decide,
    output logic [IDX_W-1:0] bit_idx,
    output logic             fast,
    output logic             loop_close,
    output logic             done
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam int PH_W  = $clog2(CODE_W + 2);

    cal_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [PH_W-1:0]  ph;
    logic             main_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            ph         <= '0;
            loop_close <= 1'b0;
            done       <= 1'b0;
            main_seen  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (chan_req) begin
                st         <= ST_HOLD;
                cnt        <= CNT_W'(HOLD_CYC - 1);
                ph         <= '0;
                loop_close <= 1'b0;
            end else begin
                case (st)
                    ST_HOLD: begin
                        if (cnt == '0) begin
                            st        <= ST_MEAS;
                            main_seen <= 1'b0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_MEAS: begin
                        if (main_rise) main_seen <= 1'b1;
                        if (ref_rise) begin
                            if (ph == PH_W'(CODE_W)) begin
                                st         <= ST_IDLE;
                                loop_close <= 1'b1;
                                done       <= 1'b1;
                            end else begin
                                ph  <= ph + 1'b1;
                                st  <= ST_HOLD;
                                cnt <= '0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign hold    = (st == ST_HOLD);
    assign active  = (st != ST_IDLE);
    assign decide  = (st == ST_MEAS) && ref_rise && (ph != '0) && !chan_req;
    assign fast    = main_seen | main_rise;
    assign bit_idx = IDX_W'(CODE_W - int'(ph));
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
    import vbc_pkg::*;
#(
    parameter int CODE_W      = CAL_CODE_W,
    parameter int HOLD_CYC    = CAL_HOLD,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_req,
    input  logic              ref_div_in,
    input  logic              main_div_in,
    output logic [CODE_W-1:0] band_code,
    output logic              precharge_en,
    output logic              div_reset,
    output logic              loop_close,
    output logic              cal_busy,
    output logic              cal_done
);
    localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

    logic             hold, active, decide, fast, ref_rise, main_rise;
    logic [IDX_W-1:0] bit_idx;

    vbc_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .clr(hold), .din(ref_div_in), .rise(ref_rise)
    );

    vbc_edge_sync #(.STAGES(SYNC_STAGES)) u_main_sync (
        .clk(clk), .rst(rst), .clr(hold), .din(main_div_in), .rise(main_rise)
    );

    vbc_seq #(.CODE_W(CODE_W), .HOLD_CYC(HOLD_CYC), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .chan_req(chan_req),
        .ref_rise(ref_rise), .main_rise(main_rise),
        .hold(hold), .active(active), .decide(decide),
        .bit_idx(bit_idx), .fast(fast),
        .loop_close(loop_close), .done(cal_done)
    );

    vbc_sar #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_sar (
        .clk(clk), .rst(rst), .load_mid(chan_req), .decide(decide),
        .bit_idx(bit_idx), .fast(fast), .code(band_code)
    );

    assign precharge_en = active;
    assign cal_busy     = active;
    assign div_reset    = hold;
endmodule

// File: rtl/vco_band_cal_chk.sv
module vco_band_cal_chk #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              chan_req,
    input logic [CODE_W-1:0] band_code,
    input logic              div_reset,
    input logic              loop_close,
    input logic              cal_busy,
    input logic              cal_done
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    assert_req_restart_R9: assert property (@(posedge clk) disable iff (rst)
        chan_req |=> (cal_busy && band_code == MID && !loop_close));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_done);

    assert_done_closes_R8: assert property (@(posedge clk) disable iff (rst)
        cal_done |-> (loop_close && !cal_busy));

    assert_closed_idle_R8: assert property (@(posedge clk) disable iff (rst)
        loop_close |-> !cal_busy);

    assert_reset_in_cal_R3: assert property (@(posedge clk) disable iff (rst)
        div_reset |-> cal_busy);

    assert_code_held_R5: assert property (@(posedge clk) disable iff (rst)
        (div_reset && !chan_req) |=> $stable(band_code));
endmodule

bind vco_band_cal vco_band_cal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst(rst), .chan_req(chan_req), .band_code(band_code),
    .div_reset(div_reset), .loop_close(loop_close),
    .cal_busy(cal_busy), .cal_done(cal_done)
);

// File: tb/vco_band_cal_test.sv
module vco_band_cal_test;
    localparam int H = 4;
    localparam int MAIN_BASE = 20;
    localparam int MAIN_STEP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_req = 1'b0;
    logic       ref_div = 1'b0;
    logic       main_div = 1'b0;
    logic [2:0] band_code;
    logic       precharge_en, div_reset, loop_close, cal_busy, cal_done;

    int tests = 0;
    int fails = 0;
    int nr = 25;
    int ref_cnt = 0;
    int main_cnt = 0;
    int cycles = 0;
    bit checking = 0;

    // behavioural reference model state
    int       m_busy, m_lc, m_done, m_rs, m_ph, m_left;
    bit [2:0] m_code;

    vco_band_cal #(.CODE_W(3), .HOLD_CYC(H)) uut (
        .clk(clk), .rst(rst), .chan_req(chan_req),
        .ref_div_in(ref_div), .main_div_in(main_div),
        .band_code(band_code), .precharge_en(precharge_en),
        .div_reset(div_reset), .loop_close(loop_close),
        .cal_busy(cal_busy), .cal_done(cal_done)
    );

    always #10 clk = ~clk;

    function automatic int main_period(input int code);
        return MAIN_BASE + MAIN_STEP * code;
    endfunction

    function automatic int best_code(input int n);
        int best = 0;
        for (int c = 0; c < 8; c++) if (main_period(c) <= n) best = c;
        return best;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_lc = 0; m_done = 0; m_rs = 0; m_ph = 0; m_left = 0; m_code = 3'b100;
        end else begin
            m_done = 0;
            if (chan_req) begin
                m_busy = 1; m_lc = 0; m_rs = H; m_ph = 0; m_code = 3'b100; m_left = H + nr + 2;
            end else begin
                if (m_rs > 0) m_rs--;
                if (m_busy != 0) begin
                    if (m_left == 1) begin
                        if (m_ph > 0) begin
                            int b;
                            b = 3 - m_ph;
                            m_code[b] = (main_period(int'(m_code)) <= nr);
                            if (b > 0) m_code[b-1] = 1'b1;
                        end
                        if (m_ph == 3) begin
                            m_busy = 0; m_lc = 1; m_done = 1;
                        end else begin
                            m_ph++; m_rs = 1; m_left = nr + 3;
                        end
                    end else begin
                        m_left--;
                    end
                end
            end
        end
    end

    // per-clock comparison, then divider models, all on the falling edge
    always @(negedge clk) begin
        if (checking) begin
            chk("R5", "band_code", int'(band_code), int'(m_code));
            chk("R2", "cal_busy", int'(cal_busy), m_busy);
            chk("R2", "precharge_en", int'(precharge_en), m_busy);
            chk("R3", "div_reset", int'(div_reset), int'(m_rs > 0));
            chk("R8", "loop_close", int'(loop_close), m_lc);
            chk("R8", "cal_done", int'(cal_done), m_done);
        end
        if (div_reset) begin
            ref_cnt = 0; main_cnt = 0; ref_div = 0; main_div = 0;
        end else begin
            ref_cnt++; main_cnt++;
            ref_div = (ref_cnt == nr);
            if (ref_cnt == nr) ref_cnt = 0;
            main_div = (main_cnt == main_period(int'(band_code)));
            if (main_cnt == main_period(int'(band_code))) main_cnt = 0;
        end
    end

    task automatic request();
        @(negedge clk); chan_req = 1'b1;
        @(negedge clk); chan_req = 1'b0;
    endtask

    task automatic run_cal(input int n, input string tag);
        int k;
        nr = n;
        request();
        k = 0;
        while (k < H + n + 1) begin @(negedge clk); k++; end
        chk("R6", {"align window code ", tag}, int'(band_code), 4);
        do begin @(negedge clk); k++; end while (!cal_done && k < 2000);
        chk("R7", {"done latency ", tag}, k, H + 4 * n + 11);
        chk("R5", {"final code ", tag}, int'(band_code), best_code(n));
        chk("R8", {"loop closed ", tag}, int'(loop_close), 1);
        @(negedge clk);
        chk("R8", {"done one cycle ", tag}, int'(cal_done), 0);
        chk("R8", {"loop stays closed ", tag}, int'(loop_close), 1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset code", int'(band_code), 4);
        chk("R1", "reset outputs",
            int'({precharge_en, div_reset, loop_close, cal_busy, cal_done}), 0);
        rst = 1'b0;
        checking = 1;
        repeat (40) @(negedge clk);
        chk("R1", "idle code ignores dividers", int'(band_code), 4);

        run_cal(25, "n25");      // R5 mixed decisions, code 2
        run_cal(26, "n26 tie");  // R4 equal edges count as fast, code 3
        run_cal(19, "n19");      // R4 all slow, code 0
        run_cal(40, "n40");      // R4 all fast, code 7
        run_cal(31, "n31");      // R5 code 5

        // R9: restart in the middle of a calibration
        nr = 30;
        request();
        repeat (50) @(negedge clk);
        chk("R9", "busy mid cal", int'(cal_busy), 1);
        run_cal(30, "restart");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule